// File: doc/BRIEF.md
# CAN Receive Frame Error Checker

This block watches the sampled receive side of a CAN bus and checks each standard-format frame for the errors a receiver is responsible for. It is fed one already-timed bus sample per strobe and does no bit timing of its own. Once the bus has been recessive for long enough, a dominant sample opens a frame. The block then strips stuff bits and follows the frame field by field. The length of the data field comes from the length code in the control field.

Every non-stuff bit is passed on with a valid pulse. The block runs the 15-bit CRC over the protected part of the frame and checks that every fixed-format delimiter bit is recessive. A stuff violation, a form violation and a CRC mismatch each have their own one-cycle pulse. Each pulse fires at the bit position where a receiver must react, not at the end of the frame. A frame that completes cleanly gives a done pulse. After any error the block goes quiet until the bus has been idle again.

Top module: `can_rx_checker`

## Requirements
- R1: After reset every output is low, and the block takes a dominant sample as Start of Frame only after 11 consecutive recessive samples; an earlier dominant sample is dropped and restarts that count.
- R2: A dominant sample (logic 0) taken while armed starts a frame. Every non-stuff bit from Start of Frame through the last End of Frame bit appears on `dbit`, with a one-cycle `dbit_vld` in the clock cycle after its strobe.
- R3: A bit that follows five equal bits is a stuff bit and is dropped. This rule covers Start of Frame through the end of the CRC field, and it also applies when that bit falls where the CRC delimiter would be. A stuff bit resets the run count and counts as the first bit of a new run.
- R4: A sixth equal bit in a stuff position raises `err_stuff` for one cycle, in the cycle after its strobe, and gives no `dbit_vld`.
- R5: The bits after Start of Frame are taken in this order: an 11-bit identifier, a remote-request bit, two reserved bits, and a 4-bit length code, each sent MSB first. The data field then carries min(code, 8) bytes. A recessive remote-request bit means no data field.
- R6: The CRC uses polynomial 0x4599 with a zero start value. It covers the destuffed bits from Start of Frame through the last data bit. The received 15-bit CRC is taken MSB first, and a mismatch raises `err_crc` after the ACK delimiter sample, never earlier.
- R7: A dominant sample at the CRC delimiter, the ACK delimiter or any of the 7 End of Frame bits raises `err_form` after that sample. The ACK slot itself is not checked. A dominant ACK delimiter that follows a bad CRC raises both flags together.
- R8: After the seventh recessive End of Frame bit, `frame_done` pulses together with the last `dbit_vld`. The next dominant sample then opens a new frame with no idle wait.
- R9: After any error the block returns to idle and must again see 11 consecutive recessive samples before it accepts a Start of Frame.
- R10: Only cycles with `samp_en` high are looked at. Changes on `rx_bit` between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | One-cycle strobe marking a valid bus sample |
| rx_bit | input | 1 | Sampled bus level, 0 = dominant |
| dbit | output | 1 | Destuffed frame bit |
| dbit_vld | output | 1 | Pulse: `dbit` holds a new bit |
| frame_done | output | 1 | Pulse: a frame ended without error |
| err_stuff | output | 1 | Pulse: stuff rule violated |
| err_form | output | 1 | Pulse: dominant level on a fixed recessive bit |
| err_crc | output | 1 | Pulse: received CRC does not match |

## Verification
The bench builds frames on its own side: it computes the CRC, adds stuff bits and toggles the line between strobes. It then compares the bit stream and the exact bit position of every event. A design that flags the CRC as soon as the CRC field ends would lose the delimiter and ACK bits and report the event too early. A design that ignores the length clamp, or that reads a remote frame as carrying data, would fall out of step and flag false errors. Other cases covered are a dominant sample arriving one bit short of the idle run after an error, dominant delimiters and End of Frame bits, and an ACK delimiter that is both dominant and follows a bad CRC. A design that miscounts the idle run would start a frame nobody sent, and one that checks the wrong positions would miss or misplace the form error.

// File: rtl/can_rx_pkg.sv
// Package: shared frame-walk states and fixed protocol widths for the
// CAN receive checker. Assumes standard (11-bit identifier) frames only.
package can_rx_pkg;

    // Width of the data length code in the control field
    localparam int DLC_W = 4;
    // Number of reserved/remote control bits between identifier and DLC
    localparam int CTRL_FLAGS = 3;

    // Field the receiver is currently walking through
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_DATA = 3'd2,
        ST_CRC  = 3'd3,
        ST_CDEL = 3'd4,
        ST_ACK  = 3'd5,
        ST_ADEL = 3'd6,
        ST_EOF  = 3'd7
    } rx_state_e;

endpackage

// File: rtl/can_rx_destuff.sv
// Module: can_rx_destuff
// Tracks the run of equal levels inside the stuffing region. When the run
// reaches RUN_LEN, the next sample is flagged as a stuff slot; if that sample
// has the same level again, a stuff violation is flagged.
// Assumes: the caller holds clear_i high while no frame is open, and asserts
// active_i for every strobe inside the stuffing region (including Start of Frame).
module can_rx_destuff #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic bit_i,
    input  logic active_i,
    input  logic clear_i,
    output logic stuff_slot_o,
    output logic stuff_err_o
);

    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

    logic [RUN_W-1:0] run_q;
    logic             last_q;

    // Stuff slot and violation decode for the current sample
    always_comb begin
        stuff_slot_o = active_i && (run_q == RUN_FULL);
        stuff_err_o  = stuff_slot_o && (bit_i == last_q);
    end

    // Run-length and last-level tracking over accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            run_q  <= '0;
            last_q <= 1'b1;
        end else if (strobe_i && active_i) begin
            last_q <= bit_i;
            if (run_q == RUN_FULL || bit_i != last_q) begin
                run_q <= RUN_ONE;
            end else begin
                run_q <= run_q + RUN_ONE;
            end
        end
    end

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_FULL);

endmodule

// File: rtl/can_rx_crc.sv
// Module: can_rx_crc
// Serial CRC register, MSB-first, one bit per shift. Cleared to zero while
// clear_i is high.
// Assumes: shift_i is only high for protected bits, and never together with clear_i.
module can_rx_crc #(
    parameter int          CRC_W = 15,
    parameter logic [14:0] POLY  = 15'h4599
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] crc_q;
    logic             fb;

    // Feedback bit: incoming bit against register MSB
    always_comb fb = bit_i ^ crc_q[CRC_W-1];

    // CRC register update
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            crc_q <= '0;
        end else if (shift_i) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_W'(POLY) : '0);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/can_rx_frame_fsm.sv
// Module: can_rx_frame_fsm
// Walks one standard frame field by field. It decodes the remote bit and
// length code, collects the received CRC, checks the recessive fixed-format
// bits, and drives all registered outputs one cycle after each strobe.
// Assumes: stuff slot and stuff violation come from the destuffer for the
// same sample, and crc_i holds the CRC of the protected bits seen so far.
module can_rx_frame_fsm
    import can_rx_pkg::*;
#(
    parameter int CRC_W     = 15,
    parameter int ID_W      = 11,
    parameter int MAX_BYTES = 8,
    parameter int EOF_LEN   = 7,
    parameter int IDLE_RUN  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             bit_i,
    input  logic             stuff_slot_i,
    input  logic             stuff_err_i,
    input  logic [CRC_W-1:0] crc_i,
    output logic             region_o,
    output logic             dclear_o,
    output logic             crc_shift_o,
    output logic             dbit_o,
    output logic             dbit_vld_o,
    output logic             frame_done_o,
    output logic             err_stuff_o,
    output logic             err_form_o,
    output logic             err_crc_o
);

    localparam int HDR_BITS = ID_W + CTRL_FLAGS + DLC_W;
    localparam int CNT_W    = $clog2(HDR_BITS + MAX_BYTES * 8 + CRC_W + EOF_LEN);
    localparam int IDLE_W   = $clog2(IDLE_RUN + 1);
    localparam logic [CNT_W-1:0]  RTR_POS  = CNT_W'(ID_W);
    localparam logic [CNT_W-1:0]  DLC_POS  = CNT_W'(ID_W + CTRL_FLAGS);
    localparam logic [CNT_W-1:0]  HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0]  CRC_LAST = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0]  EOF_LAST = CNT_W'(EOF_LEN - 1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [DLC_W-1:0]  DLC_MAX  = DLC_W'(MAX_BYTES);
    localparam logic [IDLE_W-1:0] IDLE_FULL = IDLE_W'(IDLE_RUN);
    localparam logic [IDLE_W-1:0] IDLE_ONE  = IDLE_W'(1);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] data_len_q;
    logic             rtr_q;
    logic [DLC_W-1:0] dlc_q;
    logic [CRC_W-1:0] rx_crc_q;
    logic [IDLE_W-1:0] idle_cnt_q;

    logic             armed;
    logic             sof;
    logic [DLC_W-1:0] dlc_full;
    logic [DLC_W-1:0] nbytes;
    logic [CNT_W-1:0] nbits;
    logic             form_hit;
    logic             crc_hit;

    // Arming, start detection and region decode for the current sample
    always_comb begin
        armed       = (idle_cnt_q == IDLE_FULL);
        sof         = (state_q == ST_IDLE) && strobe_i && !bit_i && armed;
        region_o    = sof || (state_q == ST_HDR) || (state_q == ST_DATA) ||
                      (state_q == ST_CRC) || (state_q == ST_CDEL);
        dclear_o    = (state_q == ST_IDLE) && !sof;
        crc_shift_o = strobe_i && !stuff_slot_i &&
                      (sof || state_q == ST_HDR || state_q == ST_DATA);
    end

    // Length decode: clamp the code, and force zero bytes for a remote frame
    always_comb begin
        dlc_full = {dlc_q[DLC_W-2:0], bit_i};
        if (rtr_q) begin
            nbytes = '0;
        end else if (dlc_full > DLC_MAX) begin
            nbytes = DLC_MAX;
        end else begin
            nbytes = dlc_full;
        end
        nbits = CNT_W'(nbytes) << 3;
    end

    // Fixed-format and CRC check decode for the current sample
    always_comb begin
        form_hit = !bit_i && (state_q == ST_CDEL || state_q == ST_ADEL ||
                              state_q == ST_EOF);
        crc_hit  = (state_q == ST_ADEL) && (rx_crc_q != crc_i);
    end

    // Frame walk, idle arming and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            data_len_q   <= '0;
            rtr_q        <= 1'b0;
            dlc_q        <= '0;
            rx_crc_q     <= '0;
            idle_cnt_q   <= '0;
            dbit_o       <= 1'b0;
            dbit_vld_o   <= 1'b0;
            frame_done_o <= 1'b0;
            err_stuff_o  <= 1'b0;
            err_form_o   <= 1'b0;
            err_crc_o    <= 1'b0;
        end else begin
            dbit_vld_o   <= 1'b0;
            frame_done_o <= 1'b0;
            err_stuff_o  <= 1'b0;
            err_form_o   <= 1'b0;
            err_crc_o    <= 1'b0;
            if (strobe_i) begin
                if (state_q == ST_IDLE) begin
                    if (bit_i) begin
                        if (!armed) idle_cnt_q <= idle_cnt_q + IDLE_ONE;
                    end else if (armed) begin
                        state_q    <= ST_HDR;
                        cnt_q      <= '0;
                        dbit_o     <= bit_i;
                        dbit_vld_o <= 1'b1;
                    end else begin
                        idle_cnt_q <= '0;
                    end
                end else if (stuff_slot_i) begin
                    if (stuff_err_i) begin
                        err_stuff_o <= 1'b1;
                        state_q     <= ST_IDLE;
                        idle_cnt_q  <= '0;
                    end
                end else if (form_hit || crc_hit) begin
                    err_form_o <= form_hit;
                    err_crc_o  <= crc_hit;
                    state_q    <= ST_IDLE;
                    idle_cnt_q <= '0;
                end else begin
                    dbit_o     <= bit_i;
                    dbit_vld_o <= 1'b1;
                    cnt_q      <= cnt_q + CNT_ONE;
                    case (state_q)
                        ST_HDR: begin
                            if (cnt_q == RTR_POS) rtr_q <= bit_i;
                            if (cnt_q >= DLC_POS) dlc_q <= dlc_full;
                            if (cnt_q == HDR_LAST) begin
                                cnt_q      <= '0;
                                data_len_q <= nbits;
                                state_q    <= (nbits == '0) ? ST_CRC : ST_DATA;
                            end
                        end
                        ST_DATA: begin
                            if (cnt_q == data_len_q - CNT_ONE) begin
                                cnt_q   <= '0;
                                state_q <= ST_CRC;
                            end
                        end
                        ST_CRC: begin
                            rx_crc_q <= {rx_crc_q[CRC_W-2:0], bit_i};
                            if (cnt_q == CRC_LAST) state_q <= ST_CDEL;
                        end
                        ST_CDEL: state_q <= ST_ACK;
                        ST_ACK:  state_q <= ST_ADEL;
                        ST_ADEL: begin
                            cnt_q   <= '0;
                            state_q <= ST_EOF;
                        end
                        ST_EOF: begin
                            if (cnt_q == EOF_LAST) begin
                                frame_done_o <= 1'b1;
                                state_q      <= ST_IDLE;
                                idle_cnt_q   <= IDLE_FULL;
                            end
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // R6
    crc_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_crc_o |-> $past(state_q) == ST_ADEL);

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stuff_o || err_form_o || err_crc_o) |-> (state_q == ST_IDLE && idle_cnt_q == '0));

    // R8
    done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> ($past(state_q) == ST_EOF && dbit_vld_o));

    // R10
    vld_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbit_vld_o |-> $past(strobe_i));

endmodule

// File: rtl/can_rx_checker.sv
// Module: can_rx_checker (top)
// Receiver-side error checker for standard CAN frames. It ties together the
// destuffer, the CRC register and the frame walker.
// Assumes: samp_en marks exactly one sample per bit time, and rx_bit is
// already synchronised to clk.
module can_rx_checker #(
    parameter int          CRC_W     = 15,
    parameter logic [14:0] CRC_POLY  = 15'h4599,
    parameter int          ID_W      = 11,
    parameter int          MAX_BYTES = 8,
    parameter int          STUFF_RUN = 5,
    parameter int          EOF_LEN   = 7,
    parameter int          IDLE_RUN  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en,
    input  logic rx_bit,
    output logic dbit,
    output logic dbit_vld,
    output logic frame_done,
    output logic err_stuff,
    output logic err_form,
    output logic err_crc
);

    logic             region;
    logic             dclear;
    logic             crc_shift;
    logic             stuff_slot;
    logic             stuff_err;
    logic [CRC_W-1:0] crc_val;

    can_rx_destuff #(
        .RUN_LEN (STUFF_RUN)
    ) destuff_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (samp_en),
        .bit_i        (rx_bit),
        .active_i     (region),
        .clear_i      (dclear),
        .stuff_slot_o (stuff_slot),
        .stuff_err_o  (stuff_err)
    );

    can_rx_crc #(
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY)
    ) crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (dclear),
        .shift_i (crc_shift),
        .bit_i   (rx_bit),
        .crc_o   (crc_val)
    );

    can_rx_frame_fsm #(
        .CRC_W     (CRC_W),
        .ID_W      (ID_W),
        .MAX_BYTES (MAX_BYTES),
        .EOF_LEN   (EOF_LEN),
        .IDLE_RUN  (IDLE_RUN)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (samp_en),
        .bit_i        (rx_bit),
        .stuff_slot_i (stuff_slot),
        .stuff_err_i  (stuff_err),
        .crc_i        (crc_val),
        .region_o     (region),
        .dclear_o     (dclear),
        .crc_shift_o  (crc_shift),
        .dbit_o       (dbit),
        .dbit_vld_o   (dbit_vld),
        .frame_done_o (frame_done),
        .err_stuff_o  (err_stuff),
        .err_form_o   (err_form),
        .err_crc_o    (err_crc)
    );

    // R4
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_done, err_stuff, err_form}) && !(err_crc && (err_stuff || frame_done)));

    // R1
    quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(dbit_vld || frame_done || err_stuff || err_form || err_crc));

endmodule

// File: tb/can_rx_checker_tb.sv
`timescale 1ns/1ps
module can_rx_checker_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_en = 1'b0;
    logic rx_bit = 1'b1;
    logic dbit, dbit_vld, frame_done, err_stuff, err_form, err_crc;

    always #2.5 clk = ~clk;

    can_rx_checker dut_i (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_bit(rx_bit),
        .dbit(dbit), .dbit_vld(dbit_vld), .frame_done(frame_done),
        .err_stuff(err_stuff), .err_form(err_form), .err_crc(err_crc)
    );

    typedef struct {
        logic [3:0] code;   // {crc, form, stuff, done}
        int         pos;
        string      req;
    } ev_t;

    logic  exp_bits[$];
    ev_t   exp_ev[$];
    logic  pre_q[$];
    logic  line_q[$];
    bit    dat_q[$];
    int    tail_at;
    int    n_exp = 0;
    int    n_seen = 0;
    int    checks = 0;
    int    fails = 0;
    bit    reported = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    endtask

    function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
        logic fb;
        fb = b ^ c[14];
        c = {c[13:0], 1'b0};
        if (fb) c = c ^ 15'h4599;
        return c;
    endfunction

    // Driver: one strobe per bit; the line shows the inverse between strobes (R10)
    task automatic send_bit(input logic b);
        @(negedge clk);
        samp_en = 1'b1;
        rx_bit  = b;
        @(negedge clk);
        samp_en = 1'b0;
        rx_bit  = ~b;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    // Build the line image of a frame: R5 field order, R6 CRC, R3 stuffing
    task automatic make_frame(input logic [10:0] id, input logic rtr,
                              input logic [3:0] dlc, input logic [63:0] data,
                              input logic [14:0] crc_flip);
        logic [14:0] c;
        int nb, run;
        logic last;
        pre_q.delete(); line_q.delete(); dat_q.delete();
        pre_q.push_back(1'b0);
        for (int i = 10; i >= 0; i--) pre_q.push_back(id[i]);
        pre_q.push_back(rtr);
        pre_q.push_back(1'b0);
        pre_q.push_back(1'b0);
        for (int i = 3; i >= 0; i--) pre_q.push_back(dlc[i]);
        nb = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
        for (int i = 0; i < nb * 8; i++) pre_q.push_back(data[63 - i]);
        c = '0;
        foreach (pre_q[i]) c = crc_step(c, pre_q[i]);
        c = c ^ crc_flip;
        for (int i = 14; i >= 0; i--) pre_q.push_back(c[i]);
        run = 0;
        last = 1'b1;
        foreach (pre_q[i]) begin
            line_q.push_back(pre_q[i]);
            dat_q.push_back(1'b1);
            if (pre_q[i] == last) run++; else run = 1;
            last = pre_q[i];
            if (run == 5) begin
                line_q.push_back(~last);
                dat_q.push_back(1'b0);
                last = ~last;
                run = 1;
            end
        end
        tail_at = line_q.size();
        line_q.push_back(1'b1); dat_q.push_back(1'b1);   // CRC delimiter
        line_q.push_back(1'b0); dat_q.push_back(1'b1);   // ACK slot
        line_q.push_back(1'b1); dat_q.push_back(1'b1);   // ACK delimiter
        for (int i = 0; i < 7; i++) begin
            line_q.push_back(1'b1); dat_q.push_back(1'b1);
        end
    endtask

    task automatic push_ev(input logic [3:0] code, input string req);
        ev_t e;
        e.code = code;
        e.pos  = n_exp;
        e.req  = req;
        exp_ev.push_back(e);
    endtask

    // Send line_q; stop < 0 means a clean frame, else the event fires at index stop
    task automatic run_line(input int stop, input logic [3:0] code, input string req);
        for (int i = 0; i < line_q.size(); i++) begin
            if (i == stop) begin
                push_ev(code, req);
                send_bit(line_q[i]);
                return;
            end
            if (dat_q[i]) begin
                exp_bits.push_back(line_q[i]);
                n_exp++;
            end
            if (stop < 0 && i == line_q.size() - 1) push_ev(4'b0001, req);
            send_bit(line_q[i]);
        end
    endtask

    // Monitor: compares the bit stream and event positions away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dbit_vld) begin
                if (exp_bits.size() == 0) begin
                    chk(0, "R2", "unexpected dbit_vld", 1, 0);
                end else begin
                    logic e;
                    e = exp_bits.pop_front();
                    chk(dbit === e, "R2/R3", "dbit value", int'(dbit), int'(e));
                end
                n_seen++;
            end
            if (frame_done || err_stuff || err_form || err_crc) begin
                logic [3:0] code;
                code = {err_crc, err_form, err_stuff, frame_done};
                if (exp_ev.size() == 0) begin
                    chk(0, "R4/R7/R8", "unexpected event code", int'(code), 0);
                end else begin
                    ev_t e;
                    e = exp_ev.pop_front();
                    chk(code == e.code, e.req, "event code", int'(code), int'(e.code));
                    chk(n_seen == e.pos, e.req, "bits before event", n_seen, e.pos);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({dbit_vld, frame_done, err_stuff, err_form, err_crc} == 5'b0,
            "R1", "outputs after reset", int'({dbit_vld, frame_done, err_stuff, err_form, err_crc}), 0);

        // R1: dominant before 11 recessive samples is dropped
        send_idle(6);
        send_bit(1'b0);
        send_idle(11);

        // R2 R5 R6 R8: plain data frame
        make_frame(11'h123, 1'b0, 4'd2, 64'hA50F_0000_0000_0000, 15'h0);
        run_line(-1, 4'b0, "R8");
        // R8: back-to-back frame, heavy stuffing (R3)
        make_frame(11'h000, 1'b0, 4'd0, 64'h0, 15'h0);
        run_line(-1, 4'b0, "R3");
        // R5: full eight bytes of ones
        make_frame(11'h7F0, 1'b0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 15'h0);
        run_line(-1, 4'b0, "R5");
        // R5: length code above eight clamped to eight bytes
        make_frame(11'h2AA, 1'b0, 4'd13, 64'h0123_4567_89AB_CDEF, 15'h0);
        run_line(-1, 4'b0, "R5");
        // R5: remote frame carries no data field
        make_frame(11'h155, 1'b1, 4'd4, 64'hDEAD_BEEF_0000_0000, 15'h0);
        run_line(-1, 4'b0, "R5");

        // R4: sixth equal dominant bit
        line_q.delete(); dat_q.delete();
        for (int i = 0; i < 6; i++) begin
            line_q.push_back(1'b0);
            dat_q.push_back(1'b1);
        end
        run_line(5, 4'b0010, "R4");

        // R9: ten recessive samples then dominant is ignored, then rearm
        send_idle(10);
        send_bit(1'b0);
        send_idle(11);

        // R6: corrupted CRC flagged only after the ACK delimiter
        make_frame(11'h3C3, 1'b0, 4'd3, 64'h1122_3300_0000_0000, 15'h0004);
        run_line(tail_at + 2, 4'b1000, "R6");
        send_idle(11);

        // R7: dominant CRC delimiter
        make_frame(11'h0F1, 1'b0, 4'd1, 64'h5A00_0000_0000_0000, 15'h0);
        line_q[tail_at] = 1'b0;
        run_line(tail_at, 4'b0100, "R7");
        send_idle(11);

        // R7: dominant last End of Frame bit
        make_frame(11'h246, 1'b0, 4'd1, 64'hC300_0000_0000_0000, 15'h0);
        line_q[tail_at + 9] = 1'b0;
        run_line(tail_at + 9, 4'b0100, "R7");
        send_idle(11);

        // R7 R6: dominant ACK delimiter after a bad CRC raises both
        make_frame(11'h4B1, 1'b0, 4'd2, 64'h7E81_0000_0000_0000, 15'h0100);
        line_q[tail_at + 2] = 1'b0;
        run_line(tail_at + 2, 4'b1100, "R7");
        send_idle(11);

        // R9: clean frame accepted after the idle run
        make_frame(11'h111, 1'b0, 4'd1, 64'h9900_0000_0000_0000, 15'h0);
        run_line(-1, 4'b0, "R9");

        repeat (10) @(negedge clk);
        chk(exp_bits.size() == 0, "R2", "undelivered bits", exp_bits.size(), 0);
        chk(exp_ev.size() == 0, "R8", "missing events", exp_ev.size(), 0);
        report();
    end

endmodule